// File: doc/BRIEF.md
# Edge-Detecting Interrupt Input Port

This block conditions three input pins and turns their transitions into interrupt request flags. A mode bit chooses where the three conditioned lines come from. In digital mode each line follows its own pin. In analog mode the first two lines follow the decisions of two external comparators, each of which compares one pin against the third pin as a reference. The third line then reads as a constant 1. The analog comparators are outside the block. Only their digital results enter it.

Every raw input passes through a synchronizer first. Four edge detectors watch the conditioned lines, and each has a fixed polarity. The middle line feeds two interrupts, one on each edge direction. When an edge is detected, a sticky flag is set. Software clears the flags by writing ones. The first conditioned line also leaves the block as the external count input for a timer. Edge detection is blocked for one cycle after a mode change, so switching the source cannot raise an interrupt on its own.

Top module: `irq_edge_port`

## Requirements
- R1: During and after reset all four flags read 0 and the synchronizers hold the idle level 1, so `rd_data_o` reads 3'b111 while the pins are held high.
- R2: In digital mode (`analog_mode_i`=0), `rd_data_o[k]` equals `pin_i[k]` for k=0..2, delayed by SYNC_STAGES clock edges.
- R3: In analog mode (`analog_mode_i`=1), `rd_data_o[0]` follows `cmp_i[0]`, `rd_data_o[1]` follows `cmp_i[1]`, and `rd_data_o[2]` reads 1 whatever `pin_i[2]` does.
- R4: Flag bit 2 of `irq_o` is set by a 1-to-0 transition of `rd_data_o[0]`. A 0-to-1 transition does not set it.
- R5: A 1-to-0 transition of `rd_data_o[1]` sets flag bit 0. A 0-to-1 transition of `rd_data_o[1]` sets flag bit 3.
- R6: A 1-to-0 transition of `rd_data_o[2]` sets flag bit 1. In analog mode this flag cannot be set by `pin_i[2]`.
- R7: Flags stay set until a cycle with `clr_we_i`=1 and a 1 in the matching bit of `clr_data_i`. Zero bits in `clr_data_i` leave their flags unchanged.
- R8: When a set and a clear of the same flag fall on the same cycle, the flag ends up set.
- R9: On the clock edge where the registered mode changes, and for the detection that follows it, no flag is set, even if the conditioned lines change value.
- R10: `tmr_in_o` equals `rd_data_o[0]` in both modes.
- R11: A flag becomes visible SYNC_STAGES+1 clock edges after the pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Raw pin levels (bit k is pin k+1) |
| cmp_i | input | 2 | Comparator decisions for pins 1 and 2 against pin 3 |
| analog_mode_i | input | 1 | Source select: 0 digital, 1 comparator |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_data_i | input | 4 | Write-one-to-clear mask for the flags |
| rd_data_o | output | 3 | Conditioned line values as read by software |
| irq_o | output | 4 | Sticky interrupt request flags |
| tmr_in_o | output | 1 | Conditioned line 0, routed to the timer |

## Verification
The bench builds the block with SYNC_STAGES=2 and idle level 1. With these values the read latency is exactly two edges and the flag latency exactly three, and the bench samples at those cycles, including the cycle just before a flag appears. Because the idle level is 1, the bench can hold the pins high through reset without a false rising edge on line 1. The bench also times the clear strobe so it lands on the same edge as a set. It switches modes while the comparator and pin levels differ from the current conditioned values, which makes the suppression window observable at the flags.

// File: rtl/irq_port_pkg.sv
package irq_port_pkg;

    localparam int NPIN = 3;
    localparam int NCMP = NPIN - 1;
    localparam int NIRQ = 4;

    typedef logic [NPIN-1:0] pin_vec_t;
    typedef logic [NIRQ-1:0] irq_vec_t;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_t;

    // conditioned line feeding each flag
    function automatic int irq_src(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

    function automatic edge_pol_t irq_pol(input int idx);
        return (idx == 3) ? EDGE_RISE : EDGE_FALL;
    endfunction

    typedef struct packed {
        logic     mode;
        logic     mode_prev;
        pin_vec_t cond_prev;
        irq_vec_t irq;
    } port_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {W{RST_VAL}};
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
    import irq_port_pkg::*;
(
    input  logic            analog_sel,
    input  pin_vec_t        pin_s,
    input  logic [NCMP-1:0] cmp_s,
    output pin_vec_t        cond
);
    always_comb begin
        cond = pin_s;
        if (analog_sel) begin
            cond[NCMP-1:0] = cmp_s;
            cond[NPIN-1]   = 1'b1; // reference pin reads high
        end
    end
endmodule

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
    import irq_port_pkg::*;
#(
    parameter edge_pol_t POL = EDGE_FALL
) (
    input  logic cur,
    input  logic prev,
    input  logic en,
    output logic pulse
);
    if (POL == EDGE_RISE) begin : g_rise
        assign pulse = en & cur & ~prev;
    end else begin : g_fall
        assign pulse = en & ~cur & prev;
    end
endmodule

// File: rtl/irq_edge_port.sv
module irq_edge_port
    import irq_port_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NCMP-1:0] cmp_i,
    input  logic            analog_mode_i,
    input  logic            clr_we_i,
    input  logic [NIRQ-1:0] clr_data_i,
    output logic [NPIN-1:0] rd_data_o,
    output logic [NIRQ-1:0] irq_o,
    output logic            tmr_in_o
);
    localparam int SW = NPIN + NCMP;

    port_state_t     state_d, state_q;
    logic [SW-1:0]   raw_s;
    pin_vec_t        cond;
    irq_vec_t        set_pulse;
    irq_vec_t        clr_mask;
    logic            detect_en;

    irq_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cmp_i, pin_i}),
        .dout (raw_s)
    );

    irq_src_mux u_mux (
        .analog_sel(state_q.mode),
        .pin_s     (raw_s[NPIN-1:0]),
        .cmp_s     (raw_s[SW-1:NPIN]),
        .cond      (cond)
    );

    // one-cycle blanking window right after the source switches
    assign detect_en = (state_q.mode == state_q.mode_prev);

    for (genvar g = 0; g < NIRQ; g++) begin : g_irq
        irq_edge_cell #(.POL(irq_pol(g))) u_cell (
            .cur  (cond[irq_src(g)]),
            .prev (state_q.cond_prev[irq_src(g)]),
            .en   (detect_en),
            .pulse(set_pulse[g])
        );
    end

    assign clr_mask = clr_we_i ? clr_data_i : '0;

    always_comb begin
        state_d           = state_q;
        state_d.mode      = analog_mode_i;
        state_d.mode_prev = state_q.mode;
        state_d.cond_prev = cond;
        state_d.irq       = (state_q.irq & ~clr_mask) | set_pulse; // set wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode      <= 1'b0;
            state_q.mode_prev <= 1'b0;
            state_q.cond_prev <= {NPIN{IDLE_LEVEL}};
            state_q.irq       <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data_o = cond;
    assign irq_o     = state_q.irq;
    assign tmr_in_o  = cond[0];

    // R9: a source switch must not raise any flag
    a_r9_no_edge_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q.mode) |=> ((irq_o & ~$past(irq_o)) == '0));

    // R7: flags only drop where a clear was requested
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irq_o) & ~$past(clr_mask)) & ~irq_o) == '0));

    // R3: reference line reads high in analog mode
    a_r3_ref_high: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.mode |-> rd_data_o[NPIN-1]);

    // R4: flag 2 appears only after a falling line 0
    a_r4_fall_line0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[2]) |-> ($past(rd_data_o[0], 2) && !$past(rd_data_o[0])));

    // R5: flag 3 appears only after a rising line 1
    a_r5_rise_line1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[3]) |-> (!$past(rd_data_o[1], 2) && $past(rd_data_o[1])));
endmodule

// File: tb/test_irq_edge_port.sv
module test_irq_edge_port;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_i = 3'b111;
    logic [1:0] cmp_i = 2'b11;
    logic       analog_mode_i = 1'b0;
    logic       clr_we_i = 1'b0;
    logic [3:0] clr_data_i = 4'b0;
    logic [2:0] rd_data_o;
    logic [3:0] irq_o;
    logic       tmr_in_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_edge_port #(.SYNC_STAGES(SYNC), .IDLE_LEVEL(1'b1)) i_irq_edge_port (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cmp_i(cmp_i),
        .analog_mode_i(analog_mode_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o), .tmr_in_o(tmr_in_o)
    );

    typedef struct {
        logic [3:0] irq;
        logic [2:0] rd;
        logic       tmr;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event sb_ev;

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (irq_o !== e.irq || rd_data_o !== e.rd || tmr_in_o !== e.tmr) begin
                    n_fail++;
                    $display("FAIL %s: irq=%b rd=%b tmr=%b, expected irq=%b rd=%b tmr=%b",
                             e.tag, irq_o, rd_data_o, tmr_in_o, e.irq, e.rd, e.tmr);
                end
            end
        end
    end

    task automatic expect_now(input logic [3:0] irq, input logic [2:0] rd,
                              input logic tmr, input string tag);
        exp_t e;
        e.irq = irq; e.rd = rd; e.tmr = tmr; e.tag = tag;
        sb_q.push_back(e);
        -> sb_ev;
        #1;
    endtask

    task automatic drive(input logic [2:0] p, input logic [1:0] c, input logic m);
        @(negedge clk);
        pin_i = p; cmp_i = c; analog_mode_i = m;
    endtask

    task automatic settle();
        repeat (LAT) @(negedge clk);
    endtask

    task automatic clear(input logic [3:0] mask);
        @(negedge clk);
        clr_we_i = 1'b1; clr_data_i = mask;
        @(negedge clk);
        clr_we_i = 1'b0; clr_data_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_now(4'b0000, 3'b111, 1'b1, "R1 reset state");

        drive(3'b110, 2'b11, 1'b0); settle();
        expect_now(4'b0100, 3'b110, 1'b0, "R4 R2 R10 line0 falls");
        clear(4'b0000);
        expect_now(4'b0100, 3'b110, 1'b0, "R7 zero mask keeps flag");
        clear(4'b0100);
        expect_now(4'b0000, 3'b110, 1'b0, "R7 one clears flag");
        drive(3'b111, 2'b11, 1'b0); settle();
        expect_now(4'b0000, 3'b111, 1'b1, "R4 rising line0 ignored");

        drive(3'b101, 2'b11, 1'b0); settle();
        expect_now(4'b0001, 3'b101, 1'b1, "R5 line1 falls");
        drive(3'b111, 2'b11, 1'b0); settle();
        expect_now(4'b1001, 3'b111, 1'b1, "R5 line1 rises");
        drive(3'b011, 2'b11, 1'b0); settle();
        expect_now(4'b1011, 3'b011, 1'b1, "R6 line2 falls");
        clear(4'b1111);
        drive(3'b111, 2'b11, 1'b0); settle();
        expect_now(4'b0000, 3'b111, 1'b1, "R7 full clear");

        // R8: clear strobe lands on the setting edge
        drive(3'b110, 2'b11, 1'b0);
        repeat (LAT - 1) @(negedge clk);
        clr_we_i = 1'b1; clr_data_i = 4'b0100;
        @(negedge clk);
        clr_we_i = 1'b0; clr_data_i = '0;
        expect_now(4'b0100, 3'b110, 1'b0, "R8 set wins over clear");
        clear(4'b0100);
        drive(3'b111, 2'b11, 1'b0); settle();
        expect_now(4'b0000, 3'b111, 1'b1, "R8 cleanup");

        // comparators low while digital: no effect on lines
        drive(3'b111, 2'b00, 1'b0); settle();
        expect_now(4'b0000, 3'b111, 1'b1, "R2 cmp ignored in digital");
        drive(3'b111, 2'b00, 1'b1); settle();
        expect_now(4'b0000, 3'b100, 1'b0, "R9 R3 switch to analog no flag");

        drive(3'b111, 2'b01, 1'b1); settle();
        expect_now(4'b0000, 3'b101, 1'b1, "R3 R10 cmp0 high");
        drive(3'b111, 2'b00, 1'b1); settle();
        expect_now(4'b0100, 3'b100, 1'b0, "R4 analog cmp0 falls");
        drive(3'b011, 2'b00, 1'b1); settle();
        expect_now(4'b0100, 3'b100, 1'b0, "R6 R3 pin3 ignored in analog");
        drive(3'b011, 2'b10, 1'b1); settle();
        expect_now(4'b1100, 3'b110, 1'b0, "R5 analog cmp1 rises");

        drive(3'b011, 2'b10, 1'b0); settle();
        expect_now(4'b1100, 3'b011, 1'b1, "R9 R10 switch to digital no flag");

        clear(4'b1111);
        drive(3'b010, 2'b10, 1'b0);
        repeat (SYNC) @(negedge clk);
        expect_now(4'b0000, 3'b010, 1'b0, "R11 R2 read ready, flag not yet");
        @(negedge clk);
        expect_now(4'b0100, 3'b010, 1'b0, "R11 flag after latency");

        #1;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule